// File: doc/BRIEF.md
# Multi-Comparator Event Timer

This block is a timer unit built around a single main counter that only counts upward. Three compare channels watch that counter, and each channel has its own target register. When the counter reaches a channel's target, the channel latches a status flag. If the channel's interrupt enable is set, it also raises its own interrupt line. The counter wraps from all-ones to zero and never runs backward. Each tick is one clock, so the block is meant to run from a clock of at least 10 MHz, which keeps one tick at 100 ns or less.

Software reaches the unit through a small word-addressed register port with separate read and write strobes:

| Word | Register |
|------|----------|
| 0 | Counter |
| 1, 2, 3 | Targets for channels 0, 1 and 2 |
| 4 | Control |
| 5 | Status |

In the control word, bit 0 starts the counter. Bit 1+i enables the interrupt of channel i. In the status word, bit i is the flag of channel i, and writing 1 to a bit clears it. Read data comes back one clock after the read strobe, together with a valid pulse.

Top module: `event_timer_unit`

## Requirements
- R1: After reset, the counter, all three targets, the control word and the status word read as zero, and `irq` is 0.
- R2: While control bit 0 is 1, the counter rises by exactly one on every clock and wraps from 0xFFFFFFFF to 0. While control bit 0 is 0, the counter holds its value.
- R3: A write to word 0 loads the counter only while control bit 0 is 0. While the counter runs, such a write is ignored.
- R4: Two reads of word 0 on back-to-back clocks while the counter runs return values that differ by one.
- R5: Status bit i is set on the clock edge at which the running counter equals target i. No match is taken while control bit 0 is 0.
- R6: Writing 1 to status bit i (word 5, bit i) clears it. Writing 0 leaves the bit unchanged.
- R7: `irq[i]` is high exactly when status bit i and control bit 1+i are both 1.
- R8: A read strobe returns `rdData` with `rdValid` high on the next clock. Words 6 and 7 read as zero.
- R9: Targets 0, 1 and 2 (words 1, 2 and 3) read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one counter tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid one cycle after `rdEn` |
| rdValid | output | 1 | Marks `rdData` as valid |
| irq | output | 3 | Per-channel interrupt lines |

## Verification
A counter that skips, stalls, or accepts a load while running shows up on the next read of word 0. It also moves every later match edge, so `irq` rises one or more cycles early or late. A bad match or status path shows at `irq` on the very clock of the expected match, and in the status word one read later. For that reason the bench checks `irq` in the cycle just before each expected match as well as in the cycle of the match itself.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int TIMER_COUNT   = 3;
  localparam int CNT_W         = 32;
  localparam int ADDR_W        = 3;
  localparam int IDX_W         = (TIMER_COUNT > 1) ? $clog2(TIMER_COUNT) : 1;
  localparam int WORD_CNT      = 0;
  localparam int WORD_CMP_BASE = 1;
  localparam int WORD_CTRL     = WORD_CMP_BASE + TIMER_COUNT;
  localparam int WORD_STAT     = WORD_CTRL + 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT,
    SEL_CMP,
    SEL_CTRL,
    SEL_STAT
  } readSel_e;

  typedef struct packed {
    logic                   cntWr;
    logic [TIMER_COUNT-1:0] cmpWr;
    logic                   ctrlWr;
    logic                   statWr;
    logic                   rdStb;
    readSel_e               rdSel;
    logic [IDX_W-1:0]       rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/evt_timer_ctrl.sv
module evt_timer_ctrl
  import evt_timer_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(WORD_CNT);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(WORD_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WORD_STAT);
  localparam logic [ADDR_W-1:0] A_CMP0 = ADDR_W'(WORD_CMP_BASE);

  logic [ADDR_W-1:0] cmpOffset;
  logic              inCmpRange;

  assign cmpOffset  = addr - A_CMP0;
  assign inCmpRange = (addr >= A_CMP0) && (cmpOffset < ADDR_W'(TIMER_COUNT));

  always_comb begin
    stb        = '0;
    stb.cntWr  = wrEn && (addr == A_CNT);
    stb.ctrlWr = wrEn && (addr == A_CTRL);
    stb.statWr = wrEn && (addr == A_STAT);
    for (int i = 0; i < TIMER_COUNT; i++) begin
      stb.cmpWr[i] = wrEn && inCmpRange && (cmpOffset == ADDR_W'(i));
    end
    stb.rdStb = rdEn;
    stb.rdIdx = IDX_W'(cmpOffset);
    if (addr == A_CNT)       stb.rdSel = SEL_CNT;
    else if (inCmpRange)     stb.rdSel = SEL_CMP;
    else if (addr == A_CTRL) stb.rdSel = SEL_CTRL;
    else if (addr == A_STAT) stb.rdSel = SEL_STAT;
    else                     stb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/evt_timer_datapath.sv
module evt_timer_datapath
  import evt_timer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  regStrobe_t             stb,
  input  logic [CNT_W-1:0]       wrData,
  output logic [CNT_W-1:0]       rdData,
  output logic                   rdValid,
  output logic [CNT_W-1:0]       cntVal,
  output logic                   cntEn,
  output logic [TIMER_COUNT-1:0] statusBits,
  output logic [TIMER_COUNT-1:0] irq
);
  localparam int CTRL_W = TIMER_COUNT + 1;

  logic [CTRL_W-1:0]      ctrlQ;
  logic [CNT_W-1:0]       cntQ;
  logic [CNT_W-1:0]       cmpQ [TIMER_COUNT];
  logic [TIMER_COUNT-1:0] statQ;
  logic [TIMER_COUNT-1:0] matchHit;
  logic [TIMER_COUNT-1:0] irqEn;
  logic [CNT_W-1:0]       rdNext;

  assign cntEn = ctrlQ[0];
  assign irqEn = ctrlQ[CTRL_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n)            ctrlQ <= '0;
    else if (stb.ctrlWr)   ctrlQ <= wrData[CTRL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  cntQ <= '0;
    else if (cntEn)              cntQ <= cntQ + CNT_W'(1);
    else if (stb.cntWr)          cntQ <= wrData;
  end

  for (genvar g = 0; g < TIMER_COUNT; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)             cmpQ[g] <= '0;
      else if (stb.cmpWr[g])  cmpQ[g] <= wrData;
    end

    assign matchHit[g] = cntEn && (cntQ == cmpQ[g]);

    always_ff @(posedge clk) begin
      if (!rst_n)                          statQ[g] <= 1'b0;
      else if (matchHit[g])                statQ[g] <= 1'b1;
      else if (stb.statWr && wrData[g])    statQ[g] <= 1'b0;
    end

    assign irq[g] = statQ[g] & irqEn[g];
  end

  always_comb begin
    rdNext = '0;
    unique case (stb.rdSel)
      SEL_CNT:  rdNext = cntQ;
      SEL_CMP:  if (int'(stb.rdIdx) < TIMER_COUNT) rdNext = cmpQ[stb.rdIdx];
      SEL_CTRL: rdNext = CNT_W'(ctrlQ);
      SEL_STAT: rdNext = CNT_W'(statQ);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.rdStb;
      if (stb.rdStb) rdData <= rdNext;
    end
  end

  assign cntVal     = cntQ;
  assign statusBits = statQ;
endmodule

// File: rtl/event_timer_unit.sv
module event_timer_unit
  import evt_timer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CNT_W-1:0]       wrData,
  output logic [CNT_W-1:0]       rdData,
  output logic                   rdValid,
  output logic [TIMER_COUNT-1:0] irq
);
  regStrobe_t             stb;
  logic [CNT_W-1:0]       cntVal;
  logic                   cntEn;
  logic [TIMER_COUNT-1:0] statusBits;

  evt_timer_ctrl ctrl_i (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .stb  (stb)
  );

  evt_timer_datapath dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .wrData     (wrData),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .cntVal     (cntVal),
    .cntEn      (cntEn),
    .statusBits (statusBits),
    .irq        (irq)
  );
endmodule

// File: rtl/event_timer_checker.sv
module event_timer_checker
  import evt_timer_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [CNT_W-1:0]       wrData,
  input logic                   rdValid,
  input logic [CNT_W-1:0]       cntVal,
  input logic                   cntEn,
  input logic [TIMER_COUNT-1:0] statusBits
);
  logic loadCnt;
  logic clrStat;

  assign loadCnt = wrEn && (addr == ADDR_W'(WORD_CNT));
  assign clrStat = wrEn && (addr == ADDR_W'(WORD_STAT));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cntEn |=> cntVal == CNT_W'($past(cntVal) + CNT_W'(1)));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntEn && !loadCnt) |=> $stable(cntVal));

  assert_load_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntEn && loadCnt) |=> cntVal == $past(wrData));

  assert_set_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (statusBits & ~$past(statusBits)) != '0 |-> $past(cntEn));

  assert_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(statusBits) & ~statusBits &
     ~($past(clrStat) ? $past(wrData[TIMER_COUNT-1:0]) : '0)) == '0);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn |=> rdValid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> !rdValid);
endmodule

bind event_timer_unit event_timer_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdValid    (rdValid),
  .cntVal     (cntVal),
  .cntEn      (cntEn),
  .statusBits (statusBits)
);

// File: tb/event_timer_unit_tb_top.sv
module event_timer_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [2:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [31:0] modelCnt;
  logic        modelRun;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_timer_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .irq(irq)
  );

  // Reference counter built from R2 and R3.
  always @(posedge clk) begin
    if (!rst_n) begin
      modelCnt <= '0;
      modelRun <= 1'b0;
    end else begin
      if (modelRun)                        modelCnt <= modelCnt + 32'd1;
      else if (wrEn && addr == 3'd0)       modelCnt <= wrData;
      if (wrEn && addr == 3'd4)            modelRun <= wrData[0];
    end
  end

  // Monitor: pops expected read data as results arrive.
  always @(negedge clk) begin
    if (rst_n && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected rdValid actual=%h expected=no read", rdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (rdData !== it.exp) begin
          failures++;
          $display("FAIL %s read actual=%h expected=%h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, input logic [31:0] e, input string tag);
    rdEn = 1'b1; addr = a;
    expQ.push_back('{exp: e, tag: tag});
    tick(1);
    rdEn = 1'b0;
    tick(1);
  endtask

  task automatic readCntPair(input string tag);
    logic [31:0] first;
    rdEn = 1'b1; addr = 3'd0;
    first = modelCnt;
    expQ.push_back('{exp: first, tag: tag});
    tick(1);
    expQ.push_back('{exp: first + 32'd1, tag: tag});
    tick(1);
    rdEn = 1'b0;
    tick(1);
  endtask

  task automatic checkIrq(input logic [2:0] e, input string tag);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state; counter and target 0 are equal but counter idle (R5)
    checkIrq(3'b000, "R1");
    readReg(3'd0, 32'd0, "R1");
    readReg(3'd1, 32'd0, "R1");
    readReg(3'd4, 32'd0, "R1");
    readReg(3'd5, 32'd0, "R1_R5");

    // R3: load while idle; R9 target readback
    writeReg(3'd0, 32'd100);
    readReg(3'd0, 32'd100, "R3");
    writeReg(3'd1, 32'd110);
    writeReg(3'd2, 32'd105);
    writeReg(3'd3, 32'd200);
    readReg(3'd2, 32'd105, "R9");
    readReg(3'd3, 32'd200, "R9");

    // start: run + irq enable for channels 0 and 1
    writeReg(3'd4, 32'h7);
    tick(5);
    checkIrq(3'b000, "R5 before ch1 match");
    tick(1);
    checkIrq(3'b010, "R5_R7 ch1 match");
    readReg(3'd5, 32'h2, "R5");        // ends at E+8
    writeReg(3'd5, 32'h5);             // bit1 written 0: stays (R6)
    checkIrq(3'b010, "R6 zero write");
    writeReg(3'd5, 32'h2);             // E+10
    checkIrq(3'b000, "R6 clear");
    checkIrq(3'b000, "R5 before ch0 match");
    tick(1);
    checkIrq(3'b001, "R5 ch0 match");
    tick(95);                           // beyond channel 2 match at 200
    checkIrq(3'b001, "R7 ch2 masked");
    readReg(3'd5, 32'h5, "R5_R7 status");
    readReg(3'd4, 32'h7, "R8 ctrl");
    readCntPair("R4");

    // R3: load while running ignored
    writeReg(3'd0, 32'd5);
    readReg(3'd0, modelCnt, "R3 ignored");

    // R2: hold while idle
    writeReg(3'd4, 32'h0);
    readReg(3'd0, modelCnt, "R2 hold");
    tick(4);
    readReg(3'd0, modelCnt, "R2 hold");

    // R2: wrap, with channel 0 matching at zero
    writeReg(3'd0, 32'hFFFF_FFFE);
    writeReg(3'd1, 32'd0);
    writeReg(3'd5, 32'h7);
    checkIrq(3'b000, "R6 clear all");
    readReg(3'd0, 32'hFFFF_FFFE, "R3");
    writeReg(3'd4, 32'h3);
    tick(2);
    checkIrq(3'b000, "R2 before wrap");
    tick(1);
    checkIrq(3'b001, "R2_R5 wrap match");
    readReg(3'd0, modelCnt, "R2 wrapped");
    readReg(3'd6, 32'd0, "R8 unmapped");
    readReg(3'd7, 32'd0, "R8 unmapped");
    readReg(3'd1, 32'd0, "R9");

    tick(2);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R8 missing reads actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule